// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block collects interrupt events from a serial-peripheral engine and turns them into one interrupt request line. Each of seven sources has a sticky pending bit that is set by an event and cleared by software writing a one to it. Whether a pending bit can raise the interrupt is governed by a mask. Software never writes the mask directly. Writing ones to one offset sets mask bits, writing ones to another offset clears them, and a third offset reports the current mask.

The block sits behind a simple register port: a write strobe, an address, write data and combinational read data. Bus protocol conversion happens elsewhere, and so does the serial datapath. Event inputs are sampled on every clock. A source that is a level, such as "receive data present", therefore re-arms its pending bit for as long as the condition holds.

Top module: `irqsc_ctrl`

## Requirements
- R1: With rst_n low at a clock edge, all pending bits, all mask bits and irq_o are zero after that edge.
- R2: A high src_evt bit sets the matching pending bit at the next clock edge. The pending vector reads at offset 0x04 in bits 6:0. Bit positions are: 1 mode fault, 2 transmit over watermark, 3 transmit full, 4 receive not empty. Bits 0, 5 and 6 are further sources.
- R3: A write to offset 0x04 clears every pending bit whose write-data bit is one, and leaves bits written with zero unchanged. Writing 0x7F clears all seven bits.
- R4: If an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: A source held high keeps its pending bit set across a clearing write. After the source drops, a clearing write leaves the bit at zero.
- R6: A write to offset 0x08 sets every mask bit whose write-data bit is one. Zero bits leave the mask unchanged.
- R7: A write to offset 0x0C clears every mask bit whose write-data bit is one. Zero bits leave the mask unchanged.
- R8: The mask vector reads at offset 0x10 in bits 6:0.
- R9: irq_o is a register holding the OR over all bits of (pending AND mask). It changes one clock after pending or mask changes.
- R10: Reads of 0x08, 0x0C and unmapped offsets return zero. Read-data bits above bit 6 are always zero. Writes to 0x10 and write-data bits above bit 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NSRC (7) | Event inputs, one per source, sampled every cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset for the read or write |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions watch four rules on every cycle: an event always leaves its pending bit set one edge later, even under a clearing write. The mask moves only on writes to the set and clear offsets, and in the direction those offsets name. irq_o follows the masked pending vector with exactly one cycle of lag. The write-only offsets read as zero. Only the bench's scenarios can show the end-to-end effects: the value seen at each offset after a chosen sequence of events and writes, a held level source re-arming after a clear, and a write to the read-only mask offset leaving the mask untouched.

// File: rtl/irqsc_pkg.sv
// Shared constants and types for the set/clear interrupt mask controller.
// Assumes byte offsets of at least 8 address bits.
package irqsc_pkg;

    localparam logic [7:0] OFS_PEND   = 8'h04;  // pending, read / write-one-to-clear
    localparam logic [7:0] OFS_ARM    = 8'h08;  // mask set, write-only
    localparam logic [7:0] OFS_DISARM = 8'h0C;  // mask clear, write-only
    localparam logic [7:0] OFS_VIEW   = 8'h10;  // mask view, read-only

    typedef enum logic [1:0] {
        RSEL_ZERO = 2'd0,
        RSEL_PEND = 2'd1,
        RSEL_VIEW = 2'd2
    } rsel_e;

    typedef struct packed {
        logic pend_clr;
        logic arm;
        logic disarm;
    } wstb_t;

endpackage

// File: rtl/irqsc_decode.sv
// Address decoder: turns the register port into write strobes and a read
// selector. Assumes ADDR_W >= 8; the address must match exactly, so
// unmapped offsets select nothing.
module irqsc_decode
    import irqsc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output wstb_t             stb,
    output rsel_e             rsel
);

    localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFS_ARM);
    localparam logic [ADDR_W-1:0] A_DISARM = ADDR_W'(OFS_DISARM);
    localparam logic [ADDR_W-1:0] A_VIEW   = ADDR_W'(OFS_VIEW);

    // Write strobes: one per writable offset, none for the mask view.
    always_comb begin
        stb.pend_clr = we && (addr == A_PEND);
        stb.arm      = we && (addr == A_ARM);
        stb.disarm   = we && (addr == A_DISARM);
    end

    // Read selector: only pending and mask view return data.
    always_comb begin
        if (addr == A_PEND)      rsel = RSEL_PEND;
        else if (addr == A_VIEW) rsel = RSEL_VIEW;
        else                     rsel = RSEL_ZERO;
    end

endmodule

// File: rtl/irqsc_pending.sv
// Pending bank: one sticky bit per source. An event sets the bit and a
// write-one-to-clear resets it. The event wins when both land together.
// Assumes events are synchronous to clk.
module irqsc_pending #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            clr_stb,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] pend_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // Per-source sticky flag, with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                       pend_q[i] <= 1'b0;
            else if (evt[i])                  pend_q[i] <= 1'b1;
            else if (clr_stb && clr_bits[i])  pend_q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/irqsc_mask.sv
// Mask bank: each bit is set through the arm strobe and cleared through
// the disarm strobe, and only where the write data holds a one.
// Assumes the two strobes are never active together, since they come
// from different offsets.
module irqsc_mask #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_stb,
    input  logic            disarm_stb,
    input  logic [NSRC-1:0] bits,
    output logic [NSRC-1:0] mask_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // Per-source enable flag, updated only by selected ones.
        always_ff @(posedge clk) begin
            if (!rst_n)                     mask_q[i] <= 1'b0;
            else if (arm_stb && bits[i])    mask_q[i] <= 1'b1;
            else if (disarm_stb && bits[i]) mask_q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/irqsc_irq_gen.sv
// Interrupt output stage: reduces pending AND mask to one request line and
// registers it, so the output is glitch-free and one cycle behind.
module irqsc_irq_gen #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] mask,
    output logic            irq_q
);

    logic [NSRC-1:0] live;

    // Sources that are both pending and enabled.
    always_comb live = pend & mask;

    // Registered OR-reduction of the live sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |live;
    end

endmodule

// File: rtl/irqsc_ctrl.sv
// Set/clear interrupt mask controller, top level. Wires the decoder, the
// pending bank, the mask bank and the output stage, and muxes read data.
// Assumes DATA_W >= NSRC and ADDR_W >= 8. Reads are combinational.
module irqsc_ctrl
    import irqsc_pkg::*;
#(
    parameter int NSRC   = 7,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_evt,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    wstb_t           stb;
    rsel_e           rsel;
    logic [NSRC-1:0] wbits;
    logic [NSRC-1:0] pend_vec;
    logic [NSRC-1:0] mask_vec;
    logic            unused_wdata_hi;

    // Only the source-wide low slice of the write data is meaningful.
    assign wbits           = reg_wdata[NSRC-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NSRC];

    irqsc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .we   (reg_we),
        .addr (reg_addr),
        .stb  (stb),
        .rsel (rsel)
    );

    irqsc_pending #(.NSRC(NSRC)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src_evt),
        .clr_stb  (stb.pend_clr),
        .clr_bits (wbits),
        .pend_q   (pend_vec)
    );

    irqsc_mask #(.NSRC(NSRC)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_stb    (stb.arm),
        .disarm_stb (stb.disarm),
        .bits       (wbits),
        .mask_q     (mask_vec)
    );

    irqsc_irq_gen #(.NSRC(NSRC)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_vec),
        .mask  (mask_vec),
        .irq_q (irq_o)
    );

    // Read data mux; write-only and unmapped offsets read as zero.
    always_comb begin
        case (rsel)
            RSEL_PEND: reg_rdata = DATA_W'(pend_vec);
            RSEL_VIEW: reg_rdata = DATA_W'(mask_vec);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqsc_ctrl_chk.sv
// Checker for irqsc_ctrl: watches the ports plus the pending and mask
// vectors. It is attached to every irqsc_ctrl instance by the bind below.
module irqsc_ctrl_chk
    import irqsc_pkg::*;
#(
    parameter int NSRC   = 7,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_evt,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_o,
    input logic [NSRC-1:0]   pend,
    input logic [NSRC-1:0]   mask
);

    logic armed;
    logic rst_seen_n;
    logic wr_pend, wr_arm, wr_disarm;

    assign wr_pend   = reg_we && (reg_addr == ADDR_W'(OFS_PEND));
    assign wr_arm    = reg_we && (reg_addr == ADDR_W'(OFS_ARM));
    assign wr_disarm = reg_we && (reg_addr == ADDR_W'(OFS_DISARM));

    // Track whether the previous edge was taken in reset.
    always_ff @(posedge clk) begin
        armed      <= 1'b1;
        rst_seen_n <= rst_n;
        if (armed && !rst_seen_n) begin
            AST_RST_CLEAN: assert (pend == '0 && mask == '0 && !irq_o)  // R1
                else $error("state not clear after reset");
        end
    end

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((pend & $past(src_evt)) == $past(src_evt)));  // R4

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt == '0 && !wr_pend) |=> $stable(pend));  // R3

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_arm |=> ((mask & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])));  // R6

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_disarm |=> ((mask & $past(reg_wdata[NSRC-1:0])) == '0));  // R7

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_arm || wr_disarm) |=> $stable(mask));  // R10

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & mask)) |=> irq_o);  // R9

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & mask)) |=> !irq_o);  // R9

    AST_WO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_ARM) || reg_addr == ADDR_W'(OFS_DISARM)) |-> (reg_rdata == '0));  // R10

endmodule

bind irqsc_ctrl irqsc_ctrl_chk #(
    .NSRC   (NSRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .pend      (pend_vec),
    .mask      (mask_vec)
);

// File: tb/irqsc_ctrl_bench.sv
// Directed bench for irqsc_ctrl. Inputs change on the falling edge, and
// outputs are sampled 1 ns after a falling edge.
module irqsc_ctrl_bench;

    localparam int NSRC   = 7;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [7:0] A_PEND = 8'h04, A_ARM = 8'h08, A_DIS = 8'h0C,
                           A_VIEW = 8'h10, A_BAD = 8'h1C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_evt = '0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irqsc_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_irqsc_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One write cycle; returns on the falling edge after the write edge.
    task automatic reg_write(input logic [7:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [DATA_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // One-cycle event pulse; returns on the falling edge after the set edge.
    task automatic pulse(input logic [NSRC-1:0] v);
        @(negedge clk);
        src_evt = v;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        rst_n = 1'b0; src_evt = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; src_evt = '0;
        @(negedge clk);
        reg_read(A_PEND, d); check("R1 pending after reset", d, 0);
        reg_read(A_VIEW, d); check("R1 mask after reset", d, 0);
        check("R1 irq after reset", {31'b0, irq_o}, 0);
    endtask

    task automatic t_events();
        logic [DATA_W-1:0] d;
        pulse(7'h02);
        reg_read(A_PEND, d); check("R2 mode fault bit1", d, 32'h02);
        pulse(7'h10);
        reg_read(A_PEND, d); check("R2 rx not empty bit4", d, 32'h12);
        @(negedge clk);
        check("R9 irq low with empty mask", {31'b0, irq_o}, 0);
    endtask

    task automatic t_clear();
        logic [DATA_W-1:0] d;
        reg_write(A_PEND, 32'h02);
        reg_read(A_PEND, d); check("R3 clear bit1 only", d, 32'h10);
        pulse(7'h41);
        reg_write(A_PEND, 32'h7F);
        reg_read(A_PEND, d); check("R3 clear all with 0x7F", d, 0);
    endtask

    task automatic t_mask();
        logic [DATA_W-1:0] d;
        reg_write(A_ARM, 32'h06);
        reg_read(A_VIEW, d); check("R6 R8 set 0x06", d, 32'h06);
        reg_write(A_ARM, 32'h10);
        reg_read(A_VIEW, d); check("R6 zero bits keep mask", d, 32'h16);
        reg_write(A_DIS, 32'h04);
        reg_read(A_VIEW, d); check("R7 clear bit2", d, 32'h12);
        reg_write(A_DIS, 32'h00);
        reg_read(A_VIEW, d); check("R7 zero write no change", d, 32'h12);
    endtask

    task automatic t_irq();
        logic [DATA_W-1:0] d;
        pulse(7'h08);
        @(negedge clk);
        check("R9 masked source no irq", {31'b0, irq_o}, 0);
        pulse(7'h02);
        check("R9 irq one cycle behind", {31'b0, irq_o}, 0);
        @(negedge clk); #1;
        check("R9 irq raised", {31'b0, irq_o}, 1);
        reg_write(A_PEND, 32'h7F);
        reg_read(A_PEND, d); check("R3 pending cleared", d, 0);
        check("R9 irq still high for one cycle", {31'b0, irq_o}, 1);
        @(negedge clk); #1;
        check("R9 irq dropped", {31'b0, irq_o}, 0);
    endtask

    task automatic t_race();
        logic [DATA_W-1:0] d;
        pulse(7'h0C);
        @(negedge clk);
        src_evt = 7'h04; reg_we = 1'b1; reg_addr = A_PEND; reg_wdata = 32'h0C;
        @(negedge clk);
        src_evt = '0; reg_we = 1'b0; reg_wdata = '0;
        reg_read(A_PEND, d); check("R4 event beats clear", d, 32'h04);
        reg_write(A_PEND, 32'h7F);
    endtask

    task automatic t_level();
        logic [DATA_W-1:0] d;
        @(negedge clk);
        src_evt = 7'h10;
        reg_write(A_PEND, 32'h10);
        reg_read(A_PEND, d); check("R5 held level survives clear", d, 32'h10);
        @(negedge clk);
        src_evt = '0;
        reg_write(A_PEND, 32'h10);
        reg_read(A_PEND, d); check("R5 released level clears", d, 0);
    endtask

    task automatic t_readonly();
        logic [DATA_W-1:0] d;
        @(negedge clk);
        reg_read(A_ARM, d); check("R10 arm offset reads zero", d, 0);
        reg_read(A_DIS, d); check("R10 disarm offset reads zero", d, 0);
        reg_read(A_BAD, d); check("R10 unmapped reads zero", d, 0);
        reg_write(A_VIEW, 32'h7F);
        reg_read(A_VIEW, d); check("R10 mask view write ignored", d, 32'h12);
        reg_write(A_ARM, 32'hFFFF_FF80);
        reg_read(A_VIEW, d); check("R10 high data bits ignored", d, 32'h12);
    endtask

    initial begin
        t_reset();
        t_events();
        t_clear();
        t_mask();
        t_irq();
        t_race();
        t_level();
        t_readonly();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule